// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Cycle Decoder Model

This block is a synthesizable device-side model of a small x4 fast-page-mode DRAM. A fast system clock samples the active-low row strobe, column strobe, write enable and output enable pins. The model works out which kind of memory cycle the controller is running from the order in which the strobe edges arrive. It keeps the stored nibbles in a small internal array and decides, every cycle, whether the model drives the 4-bit data bus. The shared data pins are split into an input path, an output path and a drive-enable.

Controller testbenches use it as a target. Alongside the data path it reports a code for the most recently classified cycle, a one-cycle protocol-error pulse, the row that the current strobe cycle refreshes, and its internal refresh row counter. It models neither analog timing limits, nor full device capacity, nor self-refresh retention.

Top module: `fpm_cycle_model`

## Requirements
- R1: After reset dq_oe is 0, cyc_kind is 0 (none), proto_err is 0 and rfsh_row is 0.
- R2: A row strobe fall with the column strobe high latches the row from addr. A later column strobe fall with we_n high latches the column, reports cyc_kind 1 (read) and captures the addressed nibble. dq_oe then equals NOT oe_n while the column strobe stays low.
- R3: If we_n is already low when the column strobe falls, dq_in is stored at that edge and cyc_kind becomes 2 (early write). dq_oe stays 0 until the column strobe rises, whatever oe_n does.
- R4: With the column strobe high, the bus is released. In the second sample after the strobe goes high, dq_oe is 0. Several column strobe pulses within one row strobe cycle access further columns of the same row.
- R5: If we_n falls while the column strobe is low in a read cycle and oe_n is high, dq_in is stored at the we_n edge and the drive stops. cyc_kind becomes 3 (late write) if oe_n stayed high during that column strobe cycle. It becomes 4 (read-modify-write) if oe_n was low at some point in it.
- R6: If that we_n fall comes while oe_n is low, nothing is stored, the bus keeps driving the read nibble and cyc_kind stays 1.
- R7: A row strobe fall with the column strobe high reports cyc_kind 5 (row-addressed refresh) and shows the latched row on act_row, until a column access reclassifies the cycle.
- R8: A row strobe fall while the column strobe was already low in the previous sample is a counter refresh. act_row shows the counter value and the counter advances by one, modulo the row count. cyc_kind is 6. Column strobe activity is ignored until the row strobe rises.
- R9: If the column strobe has stayed low since an access and the row strobe rises and falls again, cyc_kind is 7 (hidden refresh). The counter advances as in R8 and the previous read nibble stays on the bus until the column strobe rises.
- R10: Address bits above the row width (for rows) and above the column width (for columns) are ignored. With the default 6-bit row and 4-bit column, row 0x45 selects row 5 and column 0x93 selects column 3.
- R11: proto_err pulses for one cycle in two cases: we_n and the column strobe fall in the same sample during an open row, or we_n rises while the column strobe is low after a write. A same-sample fall is handled as an early write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Data arriving on the shared bus |
| dq_out | output | DQ_W | Data the model drives |
| dq_oe | output | 1 | Model drives the bus |
| cyc_kind | output | 3 | Last classified cycle code |
| proto_err | output | 1 | Indeterminate write-enable timing pulse |
| act_row | output | ROW_BITS | Row refreshed by the current row strobe cycle |
| rfsh_row | output | ROW_BITS | Next row of the internal refresh counter |

## Verification
Assertions check on every cycle that the bus is released once the column strobe has been high for two samples. They also check that a write cycle never drives, that a counter refresh never writes the array, that a blocked late write keeps the drive on, that a late write with output enable high stops it, and that the refresh counter steps by exactly one. Only the bench scenarios can show data integrity: that stored nibbles come back at the truncated addresses, that late and read-modify-write cycles get the right codes, that hidden refresh keeps the old data on the bus, and that the counter wraps.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    K_NONE  = 3'd0,
    K_READ  = 3'd1,
    K_EWR   = 3'd2,
    K_LWR   = 3'd3,
    K_RMW   = 3'd4,
    K_RONLY = 3'd5,
    K_CBR   = 3'd6,
    K_HID   = 3'd7
  } cyc_kind_e;

  typedef enum logic [1:0] {
    M_IDLE = 2'd0,
    M_ROW  = 2'd1,
    M_RFSH = 2'd2
  } ras_mode_e;

  localparam int N_STROBE = 3;
  localparam int E_RAS    = 0;
  localparam int E_CAS    = 1;
  localparam int E_WE     = 2;
endpackage

// File: rtl/fpm_pin_edges.sv
module fpm_pin_edges #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pins_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= pins_n[i];
    end
    assign fall[i] = prev_q[i] & ~pins_n[i];
    assign rise[i] = ~prev_q[i] & pins_n[i];
  end
endmodule

// File: rtl/fpm_cell_array.sv
module fpm_cell_array #(
  parameter int AW = 10,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fpm_rfsh_counter.sv
module fpm_rfsh_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R8: each counter refresh advances the row counter by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/fpm_cycle_ctrl.sv
module fpm_cycle_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int DQ_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cas_n,
  input  logic                         we_n,
  input  logic                         oe_n,
  input  logic [N_STROBE-1:0]          fall,
  input  logic [N_STROBE-1:0]          rise,
  input  logic [ROW_BITS-1:0]          row_in,
  input  logic [COL_BITS-1:0]          col_in,
  input  logic [ROW_BITS-1:0]          rfsh_cnt,
  input  logic [DQ_W-1:0]              rd_data,
  input  logic [DQ_W-1:0]              dq_in,
  output logic                         rfsh_inc,
  output logic                         wr_en,
  output logic [ROW_BITS+COL_BITS-1:0] wr_addr,
  output logic [DQ_W-1:0]              wr_data,
  output logic [ROW_BITS+COL_BITS-1:0] rd_addr,
  output logic                         drv,
  output logic [DQ_W-1:0]              dout,
  output cyc_kind_e                    kind,
  output logic                         err,
  output logic [ROW_BITS-1:0]          act_row
);
  ras_mode_e             mode_q, mode_d;
  logic [ROW_BITS-1:0]   row_q, row_d;
  logic [COL_BITS-1:0]   col_q, col_d;
  logic [ROW_BITS-1:0]   act_q, act_d;
  logic [DQ_W-1:0]       dout_q, dout_d;
  cyc_kind_e             kind_q, kind_d;
  logic                  drv_q, drv_d;
  logic                  hold_q, hold_d;
  logic                  wrote_q, wrote_d;
  logic                  seen_q, seen_d;
  logic                  err_q, err_d;
  logic                  row_open, cas_low_held;

  assign row_open     = (mode_q == M_ROW);
  assign cas_low_held = ~cas_n & ~fall[E_CAS];

  always_comb begin
    mode_d   = mode_q;
    row_d    = row_q;
    col_d    = col_q;
    act_d    = act_q;
    dout_d   = dout_q;
    kind_d   = kind_q;
    drv_d    = drv_q;
    hold_d   = hold_q;
    wrote_d  = wrote_q;
    seen_d   = seen_q;
    err_d    = 1'b0;
    rfsh_inc = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = {row_q, col_in};

    // column strobe released: bus off, access context closed
    if (rise[E_CAS]) begin
      drv_d   = 1'b0;
      hold_d  = 1'b0;
      wrote_d = 1'b0;
      seen_d  = 1'b0;
    end

    if (rise[E_RAS]) mode_d = M_IDLE;

    // row strobe fall: counter refresh or row activation
    if (fall[E_RAS]) begin
      if (cas_low_held) begin
        mode_d   = M_RFSH;
        act_d    = rfsh_cnt;
        rfsh_inc = 1'b1;
        kind_d   = hold_q ? K_HID : K_CBR;
      end else begin
        mode_d = M_ROW;
        row_d  = row_in;
        act_d  = row_in;
        kind_d = K_RONLY;
      end
    end

    if (fall[E_CAS] && row_open) begin
      col_d  = col_in;
      hold_d = 1'b1;
      seen_d = ~oe_n;
      if (!we_n) begin
        wr_en   = 1'b1;
        wr_addr = {row_q, col_in};
        drv_d   = 1'b0;
        wrote_d = 1'b1;
        kind_d  = K_EWR;
        err_d   = fall[E_WE];
      end else begin
        dout_d  = rd_data;
        drv_d   = 1'b1;
        wrote_d = 1'b0;
        kind_d  = K_READ;
      end
    end else begin
      if (!oe_n && !cas_n) seen_d = 1'b1;
      // write enable after the column strobe: late write or RMW
      if (fall[E_WE] && row_open && !cas_n && hold_q && !wrote_q) begin
        if (oe_n) begin
          wr_en   = 1'b1;
          wr_addr = {row_q, col_q};
          drv_d   = 1'b0;
          wrote_d = 1'b1;
          kind_d  = seen_q ? K_RMW : K_LWR;
        end
      end
      if (rise[E_WE] && !cas_n && wrote_q) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      act_q   <= '0;
      dout_q  <= '0;
      kind_q  <= K_NONE;
      drv_q   <= 1'b0;
      hold_q  <= 1'b0;
      wrote_q <= 1'b0;
      seen_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      row_q   <= row_d;
      col_q   <= col_d;
      act_q   <= act_d;
      dout_q  <= dout_d;
      kind_q  <= kind_d;
      drv_q   <= drv_d;
      hold_q  <= hold_d;
      wrote_q <= wrote_d;
      seen_q  <= seen_d;
      err_q   <= err_d;
    end
  end

  assign wr_data = dq_in;
  assign rd_addr = {row_q, col_in};
  assign drv     = drv_q;
  assign dout    = dout_q;
  assign kind    = kind_q;
  assign err     = err_q;
  assign act_row = act_q;

  // R3: a column cycle that has written never drives the bus
  a_r3_written_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_q |-> !drv_q);

  // R8: no array write while a counter refresh holds the row strobe low
  a_r8_rfsh_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RFSH) |-> !wr_en);

  // R6: write enable falling with output enable low leaves the drive on
  a_r6_blocked_keeps_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[E_WE] && !oe_n && drv_q && cas_low_held) |=> drv_q);

  // R5: a late write with output enable high stops the drive
  a_r5_late_stops_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (fall[E_WE] && oe_n && drv_q && cas_low_held && row_open) |=> !drv_q);
endmodule

// File: rtl/fpm_cycle_model.sv
module fpm_cycle_model
  import fpm_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int ADDR_W   = 8,
  parameter int DQ_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQ_W-1:0]     dq_in,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe,
  output logic [2:0]          cyc_kind,
  output logic                proto_err,
  output logic [ROW_BITS-1:0] act_row,
  output logic [ROW_BITS-1:0] rfsh_row
);
  localparam int AA_W = ROW_BITS + COL_BITS;

  logic [N_STROBE-1:0] fall, rise;
  logic                rfsh_inc, wr_en, drv;
  logic [AA_W-1:0]     wr_addr, rd_addr;
  logic [DQ_W-1:0]     wr_data, rd_data, dout;
  logic [ROW_BITS-1:0] cnt;
  cyc_kind_e           kind;
  logic                unused_addr_hi;

  assign unused_addr_hi = ^addr[ADDR_W-1:ROW_BITS];

  fpm_pin_edges #(.N(N_STROBE)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_n ({we_n, cas_n, ras_n}),
    .fall   (fall),
    .rise   (rise)
  );

  fpm_rfsh_counter #(.W(ROW_BITS)) u_rcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (rfsh_inc),
    .cnt   (cnt)
  );

  fpm_cell_array #(.AW(AA_W), .DW(DQ_W)) u_array (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  fpm_cycle_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DQ_W(DQ_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .fall     (fall),
    .rise     (rise),
    .row_in   (addr[ROW_BITS-1:0]),
    .col_in   (addr[COL_BITS-1:0]),
    .rfsh_cnt (cnt),
    .rd_data  (rd_data),
    .dq_in    (dq_in),
    .rfsh_inc (rfsh_inc),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .drv      (drv),
    .dout     (dout),
    .kind     (kind),
    .err      (proto_err),
    .act_row  (act_row)
  );

  assign dq_out   = dout;
  assign dq_oe    = drv & ~oe_n;
  assign cyc_kind = kind;
  assign rfsh_row = cnt;

  // R4: bus released once the column strobe has been high for two samples
  a_r4_hiz_cas_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n && $past(cas_n)) |-> !dq_oe);

  // R3: array writes happen only on a write-enable or column strobe fall
  a_r3_write_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fall[E_WE] || fall[E_CAS]));
endmodule

// File: tb/sim_fpm_cycle_model.sv
`timescale 1ns/1ps
module sim_fpm_cycle_model;
  logic       clk = 1'b0;
  logic       rst_n, ras_n, cas_n, we_n, oe_n;
  logic [7:0] addr;
  logic [3:0] dq_in, dq_out;
  logic       dq_oe, proto_err;
  logic [2:0] cyc_kind;
  logic [5:0] act_row, rfsh_row;

  int n_run = 0, n_fail = 0, ref_cnt = 0;
  bit done = 0;
  logic [3:0] ref_mem [1024];

  always #2.5 clk = ~clk;

  fpm_cycle_model u0 (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .proto_err(proto_err), .act_row(act_row),
    .rfsh_row(rfsh_row)
  );

  function automatic int f_idx(int row, int col);
    return ((row & 63) << 4) | (col & 15);
  endfunction

  function automatic int f_next_cnt(int c);
    return (c + 1) & 63;
  endfunction

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic open_row(int row);
    addr = 8'(row); ras_n = 1'b0; tick();
  endtask

  task automatic close_row();
    ras_n = 1'b1; tick();
  endtask

  task automatic do_read(int row, int col, string req);
    int e;
    e = int'(ref_mem[f_idx(row, col)]);
    open_row(row);
    addr = 8'(col); cas_n = 1'b0; oe_n = 1'b0; tick();
    chk(dq_oe == 1'b1, req, "read drive", int'(dq_oe), 1);
    chk(int'(dq_out) == e, req, "read data", int'(dq_out), e);
    chk(cyc_kind == 3'd1, req, "read kind", int'(cyc_kind), 1);
    cas_n = 1'b1; oe_n = 1'b1; tick();
    chk(dq_oe == 1'b0, "R4", "release after read", int'(dq_oe), 0);
    close_row();
  endtask

  task automatic do_early(int row, int col, int d);
    open_row(row);
    we_n = 1'b0; dq_in = 4'(d); addr = 8'(col); tick();
    cas_n = 1'b0; oe_n = 1'b0; tick();
    chk(cyc_kind == 3'd2, "R3", "early kind", int'(cyc_kind), 2);
    chk(dq_oe == 1'b0, "R3", "early no drive with oe low", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
    ref_mem[f_idx(row, col)] = 4'(d);
    close_row();
  endtask

  task automatic do_late(int row, int col, int d);
    open_row(row);
    addr = 8'(col); cas_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R2", "no drive with oe high", int'(dq_oe), 0);
    dq_in = 4'(d); we_n = 1'b0; tick();
    chk(cyc_kind == 3'd3, "R5", "late write kind", int'(cyc_kind), 3);
    cas_n = 1'b1; we_n = 1'b1; tick();
    ref_mem[f_idx(row, col)] = 4'(d);
    close_row();
  endtask

  task automatic do_rmw(int row, int col, int d);
    int e;
    e = int'(ref_mem[f_idx(row, col)]);
    open_row(row);
    addr = 8'(col); cas_n = 1'b0; oe_n = 1'b0; tick();
    chk(int'(dq_out) == e, "R5", "rmw read data", int'(dq_out), e);
    oe_n = 1'b1; tick();
    dq_in = 4'(d); we_n = 1'b0; tick();
    chk(cyc_kind == 3'd4, "R5", "rmw kind", int'(cyc_kind), 4);
    oe_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R5", "rmw drive stopped", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick();
    ref_mem[f_idx(row, col)] = 4'(d);
    close_row();
  endtask

  initial begin
    int e;
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; dq_in = '0;
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1; tick();
    // R1 reset state
    chk(dq_oe == 1'b0, "R1", "dq_oe", int'(dq_oe), 0);
    chk(cyc_kind == 3'd0, "R1", "kind", int'(cyc_kind), 0);
    chk(proto_err == 1'b0, "R1", "proto_err", int'(proto_err), 0);
    chk(rfsh_row == 6'd0, "R1", "rfsh_row", int'(rfsh_row), 0);

    // fill the array with page-mode early writes (R4 page mode)
    for (int r = 0; r < 64; r++) begin
      open_row(r);
      for (int c = 0; c < 16; c++) begin
        e = int'($urandom_range(15, 0));
        we_n = 1'b0; dq_in = 4'(e); addr = 8'(c); tick();
        cas_n = 1'b0; tick();
        cas_n = 1'b1; we_n = 1'b1; tick();
        ref_mem[f_idx(r, c)] = 4'(e);
      end
      close_row();
    end

    // R4: page-mode reads of several columns in one row strobe cycle
    open_row(7);
    for (int c = 2; c < 6; c++) begin
      addr = 8'(c); cas_n = 1'b0; oe_n = 1'b0; tick();
      e = int'(ref_mem[f_idx(7, c)]);
      chk(int'(dq_out) == e && dq_oe, "R4", "page read data", int'(dq_out), e);
      cas_n = 1'b1; oe_n = 1'b1; tick();
      chk(dq_oe == 1'b0, "R4", "page release", int'(dq_oe), 0);
    end
    close_row();

    // R2: read with output enable toggled inside the column cycle
    open_row(12);
    addr = 8'd9; cas_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R2", "oe high no drive", int'(dq_oe), 0);
    oe_n = 1'b0; #1;
    chk(dq_oe == 1'b1, "R2", "oe low drives", int'(dq_oe), 1);
    tick(); cas_n = 1'b1; oe_n = 1'b1; tick(); close_row();

    // directed writes of every kind
    do_early(20, 4, 4'hA); do_read(20, 4, "R3");
    do_late(21, 6, 4'h5);  do_read(21, 6, "R5");
    do_rmw(22, 8, 4'hC);   do_read(22, 8, "R5");

    // R6: late write attempted with oe low is blocked
    e = int'(ref_mem[f_idx(23, 1)]);
    open_row(23);
    addr = 8'd1; cas_n = 1'b0; oe_n = 1'b0; tick();
    dq_in = ~4'(e); we_n = 1'b0; tick();
    chk(dq_oe == 1'b1, "R6", "still driving", int'(dq_oe), 1);
    chk(int'(dq_out) == e, "R6", "old data held", int'(dq_out), e);
    chk(cyc_kind == 3'd1, "R6", "kind stays read", int'(cyc_kind), 1);
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(); close_row();
    do_read(23, 1, "R6");

    // R7: row-addressed refresh
    addr = 8'h7A; ras_n = 1'b0; tick();
    chk(cyc_kind == 3'd5, "R7", "ras-only kind", int'(cyc_kind), 5);
    chk(act_row == 6'h3A, "R7", "act_row", int'(act_row), 'h3A);
    close_row();

    // R8: counter refresh ignores column accesses
    do_read(9, 5, "R2");
    e = int'(ref_mem[f_idx(9, 5)]);
    cas_n = 1'b0; tick(); ras_n = 1'b0; tick();
    chk(cyc_kind == 3'd6, "R8", "cbr kind", int'(cyc_kind), 6);
    chk(int'(act_row) == ref_cnt, "R8", "cbr act_row", int'(act_row), ref_cnt);
    ref_cnt = f_next_cnt(ref_cnt);
    cas_n = 1'b1; tick();
    addr = 8'd5; dq_in = ~4'(e); we_n = 1'b0; tick(); cas_n = 1'b0; tick();
    chk(dq_oe == 1'b0, "R8", "no drive in refresh", int'(dq_oe), 0);
    cas_n = 1'b1; we_n = 1'b1; tick(); close_row();
    do_read(9, 5, "R8");

    // R8: distributed counter refreshes with wrap
    for (int i = 0; i < 70; i++) begin
      cas_n = 1'b0; tick(); ras_n = 1'b0; tick();
      chk(int'(act_row) == ref_cnt, "R8", "counter row", int'(act_row), ref_cnt);
      ref_cnt = f_next_cnt(ref_cnt);
      chk(int'(rfsh_row) == ref_cnt, "R8", "counter next", int'(rfsh_row), ref_cnt);
      ras_n = 1'b1; cas_n = 1'b1; tick();
    end

    // R9: hidden refresh keeps read data on the bus
    e = int'(ref_mem[f_idx(30, 11)]);
    open_row(30);
    addr = 8'd11; cas_n = 1'b0; oe_n = 1'b0; tick();
    ras_n = 1'b1; tick();
    chk(dq_oe == 1'b1, "R9", "drive across row strobe high", int'(dq_oe), 1);
    ras_n = 1'b0; tick();
    chk(cyc_kind == 3'd7, "R9", "hidden kind", int'(cyc_kind), 7);
    chk(int'(act_row) == ref_cnt, "R9", "hidden counter row", int'(act_row), ref_cnt);
    ref_cnt = f_next_cnt(ref_cnt);
    chk(int'(dq_out) == e && dq_oe, "R9", "hidden data held", int'(dq_out), e);
    cas_n = 1'b1; oe_n = 1'b1; tick(); tick();
    chk(dq_oe == 1'b0, "R9", "release at column strobe high", int'(dq_oe), 0);
    close_row();

    // R10: address truncation
    open_row(8'h45);
    chk(act_row == 6'd5, "R10", "row truncated", int'(act_row), 5);
    we_n = 1'b0; dq_in = 4'h9; addr = 8'h93; tick();
    cas_n = 1'b0; tick(); cas_n = 1'b1; we_n = 1'b1; tick(); close_row();
    ref_mem[f_idx(5, 3)] = 4'h9;
    do_read(5, 3, "R10");

    // R11: same-sample fall and write-enable release inside a write
    open_row(40);
    addr = 8'd2; dq_in = 4'h6; we_n = 1'b0; cas_n = 1'b0; tick();
    chk(proto_err == 1'b1, "R11", "simultaneous fall pulse", int'(proto_err), 1);
    chk(dq_oe == 1'b0, "R11", "no drive", int'(dq_oe), 0);
    tick();
    chk(proto_err == 1'b0, "R11", "pulse one cycle", int'(proto_err), 0);
    we_n = 1'b1; tick();
    chk(proto_err == 1'b1, "R11", "we rise in write", int'(proto_err), 1);
    cas_n = 1'b1; tick(); close_row();
    ref_mem[f_idx(40, 2)] = 4'h6;
    do_read(40, 2, "R11");

    // constrained random mix
    for (int i = 0; i < 200; i++) begin
      int r, c, d;
      r = int'($urandom_range(63, 0));
      c = int'($urandom_range(15, 0));
      d = int'($urandom_range(15, 0));
      case ($urandom_range(3, 0))
        0: do_read(r, c, "R2");
        1: do_early(r, c, d);
        2: do_late(r, c, d);
        default: do_rmw(r, c, d);
      endcase
    end
    for (int i = 0; i < 40; i++)
      do_read(int'($urandom_range(63, 0)), int'($urandom_range(15, 0)), "R2");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule